// File: doc/BRIEF.md
# Interrupt Steering and Ownership Handoff Unit

This unit decides where a host controller's interrupt requests go while the controller is shared between boot firmware and an operating system driver. Internal event pulses and an ownership-change event set sticky status bits. Each status bit has its own enable, and a master enable gates all of them. Together they form one pending condition. A single routing bit steers that pending condition either to the normal host interrupt line or to the system management interrupt line. Firmware sets the routing bit at power-up so that it receives every interrupt.

To take over, the driver writes a request bit. That write raises the ownership-change status, which is steered like any other source and so reaches the firmware handler through the management line. The firmware acknowledges by clearing the routing bit, and any interrupt that is still pending moves to the host line from the next cycle. The driver confirms the handoff by polling the routing bit. Its timeout policy lives in software.

The register window has four word addresses. Address 0 is control: bit 0 is the routing bit. Address 1 is command: bit 0 is the ownership request. Address 2 is status: bits 0..NUM_EVT-1 are the events and bit NUM_EVT is the ownership change. Address 3 is enable: it uses the same bit layout as status, and bit DATA_W-1 is the master enable. With the default parameters (NUM_EVT=4, DATA_W=8) the ownership bit is bit 4 and the master enable is bit 7. Reads are combinational on `bus_addr`. Unimplemented bits read 0.

Top module: `hsi_handoff_top`

## Requirements
- R1: After reset, every register reads 0 (the routing bit included), and both interrupt outputs are low.
- R2: With the routing bit (address 0, bit 0) at 0, an enabled pending status asserts `host_irq` only.
- R3: With the routing bit at 1, an enabled pending status asserts `smi_irq` only. The routing bit reads back the value last written to it.
- R4: Writing 1 to address 1 bit 0 sets the ownership-change status (address 2, bit NUM_EVT) on the next clock edge. Address 1 always reads 0, and writing 0 to it changes nothing.
- R5: A status bit causes an interrupt only when both its own enable bit (address 3, same position) and the master enable (address 3, bit DATA_W-1) are 1.
- R6: Status bits are write-1-to-clear, and writing 0 to a bit leaves it unchanged. When an event arrives in the same cycle as a clear of its bit, the bit stays set.
- R7: The interrupt outputs are levels that stay high for as long as an enabled status bit and the master enable remain set.
- R8: Clearing the routing bit while an interrupt is pending moves it from `smi_irq` to `host_irq` right after that write.
- R9: `host_irq` and `smi_irq` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| evt_in | input | NUM_EVT | Internal interrupt event pulses, one per source |
| host_irq | output | 1 | Normal host controller interrupt (level) |
| smi_irq | output | 1 | System management interrupt (level) |

## Verification
The assertions check several properties on every cycle:
- the two outputs are mutually exclusive;
- the management line is only high while the routing bit is set;
- no output is high without the master enable;
- an ownership request always leaves its status bit set;
- an idle status bit never rises by itself;
- a written routing bit is always taken up.

Some behaviours only the bench's scenarios can show:
- the full handoff sequence, in which a pending interrupt moves from one line to the other when the firmware clears the routing bit;
- that a write of 0 to the command register or the status register changes nothing;
- that an event wins over a simultaneous clear;
- that the outputs stay high as levels over idle cycles.

// File: rtl/hsi_pkg.sv
package hsi_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CMD  = 2'd1,
    REG_STAT = 2'd2,
    REG_EN   = 2'd3
  } reg_addr_e;

  localparam int ROUTE_BIT = 0;
  localparam int REQ_BIT   = 0;
endpackage

// File: rtl/hsi_rst_sync.sv
module hsi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/hsi_ctrl_regs.sv
module hsi_ctrl_regs
  import hsi_pkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter int DATA_W  = 8,
  localparam int SW     = NUM_EVT + 1
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              route_q,
  output logic [SW-1:0]     en_q,
  output logic              master_q,
  output logic              own_req
);
  logic          route_d;
  logic [SW-1:0] en_d;
  logic          master_d;
  logic          ctrl_we;
  logic          en_we;
  logic          unused_wbits;

  assign ctrl_we      = wr && (addr == REG_CTRL);
  assign en_we        = wr && (addr == REG_EN);
  assign own_req      = wr && (addr == REG_CMD) && wdata[REQ_BIT];
  assign unused_wbits = ^wdata;

  always_comb begin
    route_d  = route_q;
    en_d     = en_q;
    master_d = master_q;
    if (ctrl_we) route_d = wdata[ROUTE_BIT];
    if (en_we) begin
      en_d     = wdata[SW-1:0];
      master_d = wdata[DATA_W-1];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      route_q  <= 1'b0;
      en_q     <= '0;
      master_q <= 1'b0;
    end else begin
      if (ctrl_we) route_q <= route_d;
      if (en_we) begin
        en_q     <= en_d;
        master_q <= master_d;
      end
    end
  end

  // R3
  route_wr_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $past(ctrl_we) |-> (route_q == $past(wdata[ROUTE_BIT])));
endmodule

// File: rtl/hsi_status.sv
module hsi_status #(
  parameter int NUM_EVT = 4,
  localparam int SW     = NUM_EVT + 1
) (
  input  logic               clk,
  input  logic               srst_n,
  input  logic               clr_we,
  input  logic [SW-1:0]      clr_mask,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               own_req,
  output logic [SW-1:0]      stat_q
);
  logic [SW-1:0] set_vec;
  logic [SW-1:0] stat_d;

  assign set_vec = {own_req, evt_in};

  for (genvar b = 0; b < SW; b++) begin : g_bit
    always_comb begin
      stat_d[b] = stat_q[b];
      if (clr_we && clr_mask[b]) stat_d[b] = 1'b0;
      if (set_vec[b])            stat_d[b] = 1'b1;
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) stat_q[b] <= 1'b0;
      else         stat_q[b] <= stat_d[b];
    end
  end

  // R4
  own_req_sets_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $past(own_req) |-> stat_q[NUM_EVT]);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(stat_q) == '0 && $past(set_vec) == '0) |-> (stat_q == '0));
endmodule

// File: rtl/hsi_steer.sv
module hsi_steer #(
  parameter int NUM_EVT = 4,
  localparam int SW     = NUM_EVT + 1
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic [SW-1:0] stat_q,
  input  logic [SW-1:0] en_q,
  input  logic          master_q,
  input  logic          route_q,
  output logic          host_irq,
  output logic          smi_irq
);
  logic pending;

  always_comb begin
    pending  = master_q && (|(stat_q & en_q));
    host_irq = pending && !route_q;
    smi_irq  = pending && route_q;
  end

  // R9
  excl_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(host_irq && smi_irq));

  // R3
  smi_route_chk: assert property (@(posedge clk) disable iff (!srst_n)
    smi_irq |-> route_q);

  // R5
  master_gate_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (host_irq || smi_irq) |-> master_q);
endmodule

// File: rtl/hsi_handoff_top.sv
module hsi_handoff_top
  import hsi_pkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [1:0]         bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic               host_irq,
  output logic               smi_irq
);
  localparam int SW = NUM_EVT + 1;

  logic          srst_n;
  logic          route_q;
  logic [SW-1:0] en_q;
  logic          master_q;
  logic          own_req;
  logic [SW-1:0] stat_q;
  logic          stat_we;

  initial begin
    param_chk: assert (SW < DATA_W)
      else $error("status field overlaps master enable");
  end

  hsi_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  hsi_ctrl_regs #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .srst_n   (srst_n),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .route_q  (route_q),
    .en_q     (en_q),
    .master_q (master_q),
    .own_req  (own_req)
  );

  assign stat_we = bus_wr && (bus_addr == REG_STAT);

  hsi_status #(.NUM_EVT(NUM_EVT)) u_stat (
    .clk      (clk),
    .srst_n   (srst_n),
    .clr_we   (stat_we),
    .clr_mask (bus_wdata[SW-1:0]),
    .evt_in   (evt_in),
    .own_req  (own_req),
    .stat_q   (stat_q)
  );

  hsi_steer #(.NUM_EVT(NUM_EVT)) u_steer (
    .clk      (clk),
    .srst_n   (srst_n),
    .stat_q   (stat_q),
    .en_q     (en_q),
    .master_q (master_q),
    .route_q  (route_q),
    .host_irq (host_irq),
    .smi_irq  (smi_irq)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_CTRL: bus_rdata[ROUTE_BIT] = route_q;
      REG_CMD:  bus_rdata = '0;
      REG_STAT: bus_rdata[SW-1:0] = stat_q;
      REG_EN: begin
        bus_rdata[SW-1:0]   = en_q;
        bus_rdata[DATA_W-1] = master_q;
      end
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: tb/tb_hsi_handoff_top.sv
`timescale 1ns/1ps
module tb_hsi_handoff_top;
  localparam int NUM_EVT = 4;
  localparam int DATA_W  = 8;
  localparam int NV      = 14;

  typedef struct packed {
    logic       wr;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [3:0] evt;
    logic [1:0] raddr;
    logic [7:0] exp_rd;
    logic       exp_host;
    logic       exp_smi;
    logic [3:0] req;
  } vec_t;

  // Address map: 0 control, 1 command, 2 status, 3 enable.
  // Ownership status is bit 4; the master enable is bit 7.
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd3, 8'h81, 4'h0, 2'd3, 8'h81, 1'b0, 1'b0, 4'd5}, // R5: enables stored
    '{1'b0, 2'd0, 8'h00, 4'h1, 2'd2, 8'h01, 1'b1, 1'b0, 4'd2}, // R2: host path
    '{1'b1, 2'd0, 8'h01, 4'h0, 2'd0, 8'h01, 1'b0, 1'b1, 4'd3}, // R3: smi path
    '{1'b0, 2'd0, 8'h00, 4'h0, 2'd2, 8'h01, 1'b0, 1'b1, 4'd7}, // R7: level held
    '{1'b1, 2'd3, 8'h01, 4'h0, 2'd2, 8'h01, 1'b0, 1'b0, 4'd5}, // R5: master off
    '{1'b1, 2'd3, 8'h91, 4'h0, 2'd3, 8'h91, 1'b0, 1'b1, 4'd5}, // R5: master on
    '{1'b1, 2'd2, 8'h01, 4'h0, 2'd2, 8'h00, 1'b0, 1'b0, 4'd6}, // R6: W1C
    '{1'b1, 2'd1, 8'h00, 4'h0, 2'd2, 8'h00, 1'b0, 1'b0, 4'd4}, // R4: write 0
    '{1'b1, 2'd1, 8'h01, 4'h0, 2'd1, 8'h00, 1'b0, 1'b1, 4'd4}, // R4: request
    '{1'b0, 2'd0, 8'h00, 4'h0, 2'd2, 8'h10, 1'b0, 1'b1, 4'd4}, // R4: status set
    '{1'b1, 2'd0, 8'h00, 4'h0, 2'd0, 8'h00, 1'b1, 1'b0, 4'd8}, // R8: handoff
    '{1'b1, 2'd2, 8'h10, 4'h0, 2'd2, 8'h00, 1'b0, 1'b0, 4'd6}, // R6: clear own
    '{1'b0, 2'd0, 8'h00, 4'h2, 2'd2, 8'h02, 1'b0, 1'b0, 4'd5}, // R5: disabled src
    '{1'b1, 2'd2, 8'h00, 4'h0, 2'd2, 8'h02, 1'b0, 1'b0, 4'd6}  // R6: write 0 keeps
  };

  logic               clk;
  logic               rst_n;
  logic               bus_wr;
  logic [1:0]         bus_addr;
  logic [DATA_W-1:0]  bus_wdata;
  logic [DATA_W-1:0]  bus_rdata;
  logic [NUM_EVT-1:0] evt_in;
  logic               host_irq;
  logic               smi_irq;

  int n_chk;
  int n_fail;

  hsi_handoff_top #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_in    (evt_in),
    .host_irq  (host_irq),
    .smi_irq   (smi_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // One operation per cycle: drive at the falling edge, commit at the rising
  // edge, then present the read address and sample the settled outputs.
  task automatic op(input logic wr, input logic [1:0] a, input logic [7:0] d,
                    input logic [3:0] ev, input logic [1:0] ra);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; evt_in = ev;
    @(posedge clk);
    #1;
    bus_wr = 1'b0; evt_in = '0; bus_addr = ra; bus_wdata = '0;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; evt_in = '0;
    do_reset();

    // R1: reset state of every register and both outputs
    for (int a = 0; a < 4; a++) begin
      bus_addr = a[1:0];
      #1;
      chk("R1 reset read", bus_rdata, 8'h00);
    end
    chk("R1 reset host_irq", {7'd0, host_irq}, 8'h00);
    chk("R1 reset smi_irq", {7'd0, smi_irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].evt, VEC[i].raddr);
      chk($sformatf("R%0d vec %0d rdata", VEC[i].req, i), bus_rdata, VEC[i].exp_rd);
      chk($sformatf("R%0d vec %0d host_irq", VEC[i].req, i), {7'd0, host_irq}, {7'd0, VEC[i].exp_host});
      chk($sformatf("R%0d vec %0d smi_irq", VEC[i].req, i), {7'd0, smi_irq}, {7'd0, VEC[i].exp_smi});
      chk("R9 exclusive", {7'd0, host_irq & smi_irq}, 8'h00);
    end

    // R6: an event in the same cycle as a clear of its bit keeps the bit set
    op(1'b1, 2'd2, 8'h02, 4'h2, 2'd2);
    chk("R6 set beats clear", bus_rdata, 8'h02);
    op(1'b1, 2'd2, 8'h02, 4'h0, 2'd2);
    chk("R6 clear after", bus_rdata, 8'h00);

    // R7: the host level holds across idle cycles
    op(1'b1, 2'd3, 8'h81, 4'h1, 2'd2);
    repeat (3) op(1'b0, 2'd0, 8'h00, 4'h0, 2'd2);
    chk("R7 host held", {7'd0, host_irq}, 8'h01);

    // R1: a mid-run reset returns the routing bit and outputs to 0
    op(1'b1, 2'd0, 8'h01, 4'h0, 2'd0);
    chk("R3 route set", bus_rdata, 8'h01);
    do_reset();
    bus_addr = 2'd0;
    #1;
    chk("R1 route after reset", bus_rdata, 8'h00);
    chk("R1 smi after reset", {7'd0, smi_irq}, 8'h00);
    bus_addr = 2'd2;
    #1;
    chk("R1 status after reset", bus_rdata, 8'h00);

    finish_run();
  end
endmodule